// File: doc/BRIEF.md
# CAN Bit Timer and Sampler

This block recovers the bit timing on the receive side of a CAN node and decides the value of each bit. A programmable divider turns the system clock into a serial-clock enable, and one serial-clock period is one time quantum. A quantum counter steps through the four parts of a bit: the sync quantum, the propagation segment and the two phase segments. At the end of phase segment 1 the line is sampled. In single mode one reading is taken. In triple mode three readings are taken and the majority wins.

After reset the block waits, producing no strobes, until the line falls from recessive to dominant. That edge restarts the bit at the start of its sync quantum, and from then on bits run back to back. The same restart happens on any later falling edge that arrives while the last decided bit is recessive. A downstream frame decoder takes `bit_val` when `sample_stb` pulses and uses `bit_stb` to mark where each bit ends.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `bit_val` is 1 and both `sample_stb` and `bit_stb` are 0.
- R2: A time quantum lasts `presc`+1 system clocks (`presc` is 8 bits, 0 to 255).
- R3: A bit lasts 1 + (`prop_len`+1) + (`ph1_len`+1) + (`ph2_len`+1) quanta, in this order: sync, propagation, phase 1, phase 2. Each length field is 3 bits.
- R4: `sample_stb` is high for exactly one system clock. It rises in the clock after the last system clock of the last quantum of phase 1.
- R5: `bit_stb` is high for exactly one system clock. It rises in the clock after the last system clock of the last quantum of phase 2.
- R6: With `triple_mode` = 0, `bit_val` takes the level of `rx_in` at the sample point. `bit_val` changes only in the cycle in which `sample_stb` is high.
- R7: With `triple_mode` = 1, `bit_val` is the majority of three readings of `rx_in`: one at the sample point and one at the end of each of the two quanta before it.
- R8: From reset until the first falling edge of `rx_in`, neither strobe is asserted.
- R9: A falling edge of `rx_in` (1 then 0 on successive clocks) while `bit_val` is 1 restarts the current bit at the start of its sync quantum and resets the divider. The same edge while `bit_val` is 0 has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc | input | 8 | Divider value; a quantum lasts presc+1 clocks |
| prop_len | input | 3 | Propagation segment length minus one, in quanta |
| ph1_len | input | 3 | Phase segment 1 length minus one, in quanta |
| ph2_len | input | 3 | Phase segment 2 length minus one, in quanta |
| triple_mode | input | 1 | 0: one reading per bit; 1: majority of three readings |
| rx_in | input | 1 | Raw receive line, 1 is recessive |
| bit_val | output | 1 | Last decided bit value |
| sample_stb | output | 1 | One-clock pulse when a new bit_val is decided |
| bit_stb | output | 1 | One-clock pulse at the end of each bit |

## Verification
A wrong divider count or quantum count moves `sample_stb` and `bit_stb` off their expected cycles. The reference model catches this on the first strobe after the fault, which is within one bit time. A corrupted reading history or a wrong vote shows up in `bit_val` at the next sample point. A bad synchronization decision, whether a missed restart or a restart that should not happen, moves every later strobe. Comparing every clock against the behavioural model exposes each of these faults within one bit of the error.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] presc,
  input  logic [SW-1:0] prop_len,
  input  logic [SW-1:0] ph1_len,
  input  logic [SW-1:0] ph2_len,
  input  logic          triple_mode,
  input  logic          rx_in,
  output logic          bit_val,
  output logic          sample_stb,
  output logic          bit_stb
);
  localparam int QW = $clog2(3 * (1 << SW) + 2);

  logic [PW-1:0] pc;
  logic [QW-1:0] q;
  logic          running;
  logic          rx_q;
  logic [1:0]    hist;

  wire           tq_en  = (pc == presc);
  wire           hsync  = rx_q & ~rx_in & bit_val;
  wire [QW-1:0]  sp_idx = QW'(prop_len) + QW'(ph1_len) + QW'(2);
  wire [QW-1:0]  end_idx = sp_idx + QW'(ph2_len) + QW'(1);
  wire           at_sp  = running & tq_en & (q == sp_idx);
  wire           at_end = running & tq_en & (q == end_idx);
  wire           maj    = (rx_in & hist[0]) | (rx_in & hist[1]) | (hist[0] & hist[1]);
  wire           vote   = triple_mode ? maj : rx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= '0;
      q          <= '0;
      running    <= 1'b0;
      rx_q       <= 1'b1;
      hist       <= 2'b11;
      bit_val    <= 1'b1;
      sample_stb <= 1'b0;
      bit_stb    <= 1'b0;
    end else begin
      rx_q       <= rx_in;
      sample_stb <= at_sp & ~hsync;
      bit_stb    <= at_end & ~hsync;
      if (tq_en) hist <= {hist[0], rx_in};
      if (hsync) begin
        running <= 1'b1;
        pc      <= '0;
        q       <= '0;
      end else begin
        pc <= tq_en ? '0 : pc + 1'b1;
        if (at_sp) bit_val <= vote;
        if (running && tq_en) q <= (q == end_idx) ? '0 : q + 1'b1;
      end
    end
  end
endmodule

module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic triple_mode,
  input logic rx_in,
  input logic running,
  input logic bit_val,
  input logic sample_stb,
  input logic bit_stb
);
  assert_sample_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
  assert_bit_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
  assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_stb));
  assert_value_only_at_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(bit_val));
  assert_single_reading_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !triple_mode) |-> (bit_val == $past(rx_in)));
  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!sample_stb && !bit_stb));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .triple_mode(triple_mode), .rx_in(rx_in),
  .running(running), .bit_val(bit_val), .sample_stb(sample_stb), .bit_stb(bit_stb)
);

// File: tb/tb_can_bit_timer.sv
`timescale 1ns/1ps
module tb_can_bit_timer;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] presc = 0;
  logic [2:0] prop_len = 0, ph1_len = 0, ph2_len = 0;
  logic triple_mode = 0;
  logic rx_in = 1;
  logic bit_val, sample_stb, bit_stb;
  int total = 0, bad = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  can_bit_timer dut (
    .clk(clk), .rst_n(rst_n), .presc(presc), .prop_len(prop_len), .ph1_len(ph1_len),
    .ph2_len(ph2_len), .triple_mode(triple_mode), .rx_in(rx_in),
    .bit_val(bit_val), .sample_stb(sample_stb), .bit_stb(bit_stb)
  );

  // behavioural reference
  int m_div, m_quant;
  bit m_run, m_prev, m_bit, e_samp, e_bit;
  bit m_h[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_quant = 0; m_run = 0; m_prev = 1; m_bit = 1; e_samp = 0; e_bit = 0;
      m_h = {1'b1, 1'b1};
    end else begin
      int spq, lastq, votes;
      bit tick, restart;
      spq = 1 + (prop_len + 1) + (ph1_len + 1) - 1;
      lastq = spq + ph2_len + 1;
      tick = (m_div == presc);
      restart = m_prev && !rx_in && m_bit;
      e_samp = 0; e_bit = 0;
      if (restart) begin
        m_run = 1; m_div = 0; m_quant = 0;
      end else begin
        m_div = tick ? 0 : m_div + 1;
        if (m_run && tick) begin
          if (m_quant == spq) begin
            e_samp = 1;
            votes = rx_in + m_h[0] + m_h[1];
            m_bit = triple_mode ? (votes >= 2) : rx_in;
          end
          if (m_quant == lastq) begin
            e_bit = 1; m_quant = 0;
          end else m_quant = m_quant + 1;
        end
      end
      if (tick) begin
        m_h.push_front(rx_in);
        void'(m_h.pop_back());
      end
      m_prev = rx_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      total++;
      if (sample_stb !== e_samp) begin
        bad++; $display("FAIL R4 sample_stb actual=%0b expected=%0b t=%0t", sample_stb, e_samp, $time);
      end else if (bit_stb !== e_bit) begin
        bad++; $display("FAIL R5 bit_stb actual=%0b expected=%0b t=%0t", bit_stb, e_bit, $time);
      end else if (bit_val !== m_bit) begin
        bad++;
        if (triple_mode) $display("FAIL R7 bit_val actual=%0b expected=%0b t=%0t", bit_val, m_bit, $time);
        else $display("FAIL R6 bit_val actual=%0b expected=%0b t=%0t", bit_val, m_bit, $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int p, input int pr, input int a, input int b, input bit m);
    @(negedge clk);
    rst_n = 0; rx_in = 1;
    presc = 8'(p); prop_len = 3'(pr); ph1_len = 3'(a); ph2_len = 3'(b); triple_mode = m;
    repeat (3) @(negedge clk);
    check("R1 bit_val in reset", bit_val, 1);
    check("R1 strobes in reset", sample_stb | bit_stb, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 bit_val after reset", bit_val, 1);
    check("R1 strobes after reset", sample_stb | bit_stb, 0);
  endtask

  task automatic wait_sample(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_stb && n < 5000);
  endtask

  task automatic random_run(input int cycles, input int hold_max, input bit glitches);
    int left = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (left == 0) begin
        rx_in = 1'($urandom_range(0, 1));
        left = $urandom_range(1, hold_max);
      end else left--;
      if (glitches && $urandom_range(0, 19) == 0) begin
        rx_in = ~rx_in;
        @(negedge clk);
        rx_in = ~rx_in;
      end
    end
  endtask

  initial begin
    #(160000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, strobes;
    // R8: no strobes while line stays recessive
    do_reset(0, 0, 0, 0, 0);
    cmp_en = 1;
    strobes = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      strobes += sample_stb + bit_stb;
    end
    check("R8 strobes while idle", strobes, 0);

    // R9 / R3: restart on first falling edge, shortest bit: sample 4 negedges later
    rx_in = 0;
    wait_sample(n);
    check("R9 cycles from edge to first sample", n, 4);
    check("R6 sampled dominant", bit_val, 0);
    // edge while bit_val dominant must not move timing: bit = 4 quanta of 1 clock
    @(negedge clk); rx_in = 1; @(negedge clk); rx_in = 0;
    wait_sample(n);
    check("R9 edge ignored while dominant, spacing", n, 2);
    wait_sample(n);
    check("R3 sample spacing 4 quanta", n, 4);

    // R2: quantum of presc+1 clocks, spacing = 4*5
    do_reset(4, 0, 0, 0, 0);
    @(negedge clk); rx_in = 0;
    wait_sample(n);
    wait_sample(n);
    check("R2 sample spacing presc=4", n, 20);

    // R3: longest bit, presc=1: 25 quanta * 2 clocks
    do_reset(1, 7, 7, 7, 1);
    @(negedge clk); rx_in = 0;
    wait_sample(n);
    wait_sample(n);
    check("R3 sample spacing longest bit", n, 50);

    // random traffic across configurations against the model
    do_reset(0, 0, 0, 0, 0);  random_run(3000, 8, 0);
    do_reset(3, 2, 3, 1, 1);  random_run(4000, 40, 1);
    do_reset(1, 7, 7, 7, 1);  random_run(4000, 60, 1);
    do_reset(2, 1, 0, 5, 0);  random_run(4000, 30, 1);
    do_reset(0, 3, 2, 0, 1);  random_run(3000, 10, 1);

    cmp_en = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule